// File: doc/BRIEF.md
# Forty-Bit Timestamp Counter With Latched Read

This block is a free-running timestamp counter, 40 bits wide by default, seen by software through a 32-bit register window. It advances by one on every cycle in which a single-cycle tick strobe is high and the counter is enabled. The tick is nominally 983.04 kHz and comes from a divider outside the block. The counter raises no interrupt. Its only job is to give a monotonic time base that software can sample at any moment.

Because the value is wider than the data bus, it is read in two accesses: first the low word, then the high register. The low-word read also captures the counter's upper bits into a holding latch in the same cycle. The later high read therefore returns upper bits that belong with the low word already taken, even if the counter has moved on since. The high register also holds the run/stop control bit. Software joins the two words and masks the result to the counter width.

Top module: `tsc40_stamp`

## Requirements
- R1: After reset the counter, the holding latch and the enable bit are all zero. While the enable is zero, ticks do not move the counter.
- R2: While enabled, each cycle with `tick_en` high adds exactly one to the counter. The count wraps from 2^CNT_W-1 to 0.
- R3: Clearing the enable freezes the counter at its present value. Later ticks leave it unchanged.
- R4: A read at byte offset 0x60 returns counter bits DATA_W-1:0 in the same cycle. At the clock edge of that access it copies counter bits CNT_W-1:DATA_W into the latch. When a tick falls in the same cycle, the returned low word and the latched upper bits both come from the value before the increment.
- R5: A read at byte offset 0x64 returns the latch in bits CNT_W-DATA_W-1:0, the enable in bit 8, and zero in every other bit. The latch changes only on a low-word read, so ticks alone do not alter what a high read returns.
- R6: A write at offset 0x64 sets the enable to wdata bit 8. All other wdata bits are ignored.
- R7: A write to offset 0x60, or any access to another offset, changes neither the counter, the latch nor the enable. A read of another offset returns zero, and `rdata` is zero in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Single-cycle count strobe |
| rd_en | input | 1 | Read strobe for the addressed register |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid in the cycle of `rd_en` |

## Verification
Two instances run side by side on the same stimulus: the default 40-bit one, and a 12-bit counter with a 10-bit window. The narrow one lets the bench reach the carry out of the low word and the full wrap in a few thousand cycles. Directed sequences check the reset state, run/stop, writes that must be ignored, and a low-word read that coincides with a tick at the all-ones low boundary. That last case separates a latch taken before the increment from a torn one. Seeded random mixes of ticks, reads, enable writes and stray accesses then exercise interleavings. Every cycle's read data is compared with a bench model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   // Kind of register access decoded from the strobes and the offset.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_OTHER = 2'd3
   } tsc_acc_e;

   typedef struct packed {
      tsc_acc_e kind;
      logic     is_rd;
      logic     is_wr;
   } tsc_access_t;

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int CNT_W       = 40,
   parameter int SEG_W       = 32,
   parameter bit SPLIT_CARRY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q
);

   localparam int UP_W = CNT_W - SEG_W;

   generate
      if (SEG_W < 1 || SEG_W >= CNT_W) begin : g_bad_seg
         $error("tsc_counter: SEG_W must lie in 1..CNT_W-1");
      end

      if (SPLIT_CARRY) begin : g_split
         // Low segment and upper segment with the carry taken from an AND of the low bits.
         logic [SEG_W-1:0] lo_q;
         logic [UP_W-1:0]  up_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= '0;
               up_q <= '0;
            end else if (step) begin
               lo_q <= lo_q + 1'b1;
               if (&lo_q) up_q <= up_q + 1'b1;
            end
         end
         assign cnt_q = {up_q, lo_q};
      end else begin : g_flat
         logic [CNT_W-1:0] all_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    all_q <= '0;
            else if (step) all_q <= all_q + 1'b1;
         end
         assign cnt_q = all_q;
      end
   endgenerate

   // R2: one count per enabled tick, modulo 2^CNT_W
   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R3: no enabled tick, no movement
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/tsc_snap.sv
module tsc_snap #(
   parameter int HI_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [HI_W-1:0] cnt_hi,
   output logic [HI_W-1:0] lat_q
);

   generate
      if (HI_W < 1) begin : g_bad_w
         $error("tsc_snap: HI_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_q <= '0;
      else if (capture) lat_q <= cnt_hi;
   end

   // R4: the latch takes the upper bits seen during the low-word access
   p_capture_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> lat_q == $past(cnt_hi));

   // R5: the latch is left alone between low-word reads
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(lat_q));

endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter int          HI_W   = 8,
   parameter int          EN_BIT = 8,
   parameter logic [31:0] LO_OFS = 32'h60,
   parameter logic [31:0] HI_OFS = 32'h64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_bit,
   input  logic [DATA_W-1:0] cnt_lo,
   input  logic [HI_W-1:0]   lat,
   output logic              run_q,
   output logic              rd_lo,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] LO_A = LO_OFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] HI_A = HI_OFS[ADDR_W-1:0];

   generate
      if (EN_BIT < HI_W || EN_BIT >= DATA_W) begin : g_bad_en
         $error("tsc_regs: EN_BIT must sit above the latch and inside the word");
      end
      if (LO_A == HI_A) begin : g_bad_ofs
         $error("tsc_regs: low and high offsets must differ");
      end
   endgenerate

   tsc_access_t acc;
   logic        wr_hi;

   always_comb begin
      acc.is_rd = rd_en;
      acc.is_wr = wr_en;
      if (!rd_en && !wr_en)  acc.kind = ACC_NONE;
      else if (addr == LO_A) acc.kind = ACC_LO;
      else if (addr == HI_A) acc.kind = ACC_HI;
      else                   acc.kind = ACC_OTHER;
   end

   assign rd_lo = acc.is_rd && (acc.kind == ACC_LO);
   assign wr_hi = acc.is_wr && (acc.kind == ACC_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= 1'b0;
      else if (wr_hi) run_q <= wr_bit;
   end

   always_comb begin
      rdata = '0;
      if (acc.is_rd) begin
         case (acc.kind)
            ACC_LO: rdata = cnt_lo;
            ACC_HI: begin
               rdata[HI_W-1:0] = lat;
               rdata[EN_BIT]   = run_q;
            end
            default: rdata = '0;
         endcase
      end
   end

   // R6: a high-register write sets the enable to the written bit
   p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> run_q == $past(wr_bit));

   // R7: no other access moves the enable
   p_en_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hi |=> $stable(run_q));

endmodule

// File: rtl/tsc40_stamp.sv
module tsc40_stamp #(
   parameter int          CNT_W       = 40,
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 8,
   parameter int          EN_BIT      = 8,
   parameter logic [31:0] LO_OFS      = 32'h60,
   parameter logic [31:0] HI_OFS      = 32'h64,
   parameter bit          SPLIT_CARRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int HI_W = CNT_W - DATA_W;

   generate
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt
         $error("tsc40_stamp: CNT_W must exceed DATA_W and fit in two words");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [HI_W-1:0]  lat;
   logic             run;
   logic             rd_lo;
   logic             step;

   assign step = tick_en && run;

   tsc_counter #(
      .CNT_W       (CNT_W),
      .SEG_W       (DATA_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .cnt_q (cnt)
   );

   tsc_snap #(
      .HI_W (HI_W)
   ) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_lo),
      .cnt_hi  (cnt[CNT_W-1:DATA_W]),
      .lat_q   (lat)
   );

   tsc_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .HI_W   (HI_W),
      .EN_BIT (EN_BIT),
      .LO_OFS (LO_OFS),
      .HI_OFS (HI_OFS)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .wr_en  (wr_en),
      .addr   (addr),
      .wr_bit (wdata[EN_BIT]),
      .cnt_lo (cnt[DATA_W-1:0]),
      .lat    (lat),
      .run_q  (run),
      .rd_lo  (rd_lo),
      .rdata  (rdata)
   );

   // R1: stopped counter ignores ticks
   p_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && tick_en) |=> $stable(cnt));

   // R4: the low word returned is the counter value before any increment
   p_lo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |-> rdata == cnt[DATA_W-1:0]);

endmodule

// File: tb/tsc40_stamp_bench.sv
`timescale 1ns/1ps
module tsc40_stamp_bench;

   localparam int          NI     = 2;
   localparam logic [7:0]  A_LO   = 8'h60;
   localparam logic [7:0]  A_HI   = 8'h64;
   localparam logic [7:0]  A_OTH  = 8'h68;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_big;
   logic [9:0]  rdata_sml;

   always #2.5 clk = ~clk;

   tsc40_stamp u_tsc40_stamp (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .rd_en (rd_en),
      .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata_big)
   );

   tsc40_stamp #(.CNT_W(12), .DATA_W(10), .SPLIT_CARRY(1'b0)) u_tsc40_stamp_wrap (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .rd_en (rd_en),
      .wr_en (wr_en), .addr (addr), .wdata (wdata[9:0]), .rdata (rdata_sml)
   );

   int unsigned cw [NI] = '{40, 12};
   int unsigned dw [NI] = '{32, 10};
   logic [63:0] m_cnt [NI];
   logic [63:0] m_lat [NI];
   logic        m_run;
   int          checks = 0;
   int          errs = 0;
   bit          done = 1'b0;

   function automatic logic [63:0] mask(input int unsigned w);
      return (64'd1 << w) - 64'd1;
   endfunction

   function automatic logic [63:0] exp_rd(input int i, input bit rd, input logic [7:0] a);
      if (!rd)        return 64'd0;
      if (a == A_LO)  return m_cnt[i] & mask(dw[i]);
      if (a == A_HI)  return ({63'd0, m_run} << 8) | m_lat[i];
      return 64'd0;
   endfunction

   task automatic check(input string tag, input int i, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s inst%0d actual=%h expected=%h", tag, i, act, exp);
      end
   endtask

   // One bus cycle: drive after the falling edge, check combinational read data, then advance the model.
   task automatic cyc(input bit tk, input bit rd, input bit wr, input logic [7:0] a,
                      input logic [31:0] wd, input string tag);
      @(negedge clk);
      tick_en = tk; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
      #1;
      check(tag, 0, {32'd0, rdata_big}, exp_rd(0, rd, a));
      check(tag, 1, {54'd0, rdata_sml}, exp_rd(1, rd, a));
      @(posedge clk);
      for (int i = 0; i < NI; i++) begin
         if (rd && a == A_LO) m_lat[i] = (m_cnt[i] >> dw[i]) & mask(cw[i] - dw[i]);
         if (tk && m_run)     m_cnt[i] = (m_cnt[i] + 64'd1) & mask(cw[i]);
      end
      if (wr && a == A_HI) m_run = wd[8];
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NI; i++) begin m_cnt[i] = '0; m_lat[i] = '0; end
      m_run = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state, and ticks while stopped
      cyc(0, 1, 0, A_HI, 0, "R1");
      cyc(0, 1, 0, A_LO, 0, "R1");
      for (int k = 0; k < 5; k++) cyc(1, 0, 0, A_LO, 0, "R1");
      cyc(0, 1, 0, A_LO, 0, "R1");

      // R6: start, only bit 8 matters
      cyc(0, 0, 1, A_HI, 32'h0000_0100, "R6");
      cyc(0, 1, 0, A_HI, 0, "R6");
      // R2: counting, reading back each step
      for (int k = 0; k < 20; k++) cyc(1, 1, 0, A_LO, 0, "R2");
      cyc(1, 0, 0, A_LO, 0, "R2");
      cyc(0, 1, 0, A_LO, 0, "R2");
      // R6: stop with all other bits set
      cyc(0, 0, 1, A_HI, 32'hFFFF_FEFF, "R6");
      cyc(0, 1, 0, A_HI, 0, "R6");
      // R3: frozen while stopped
      for (int k = 0; k < 6; k++) cyc(1, 1, 0, A_LO, 0, "R3");
      // R7: ignored writes and stray reads
      cyc(1, 0, 1, A_LO, 32'hFFFF_FFFF, "R7");
      cyc(0, 0, 1, A_OTH, 32'h0000_0100, "R7");
      cyc(0, 1, 0, A_OTH, 0, "R7");
      cyc(0, 1, 0, A_HI, 0, "R7");
      cyc(0, 1, 0, A_LO, 0, "R7");

      // R4: narrow instance at low-word all ones, read coincides with a tick
      cyc(0, 0, 1, A_HI, 32'h0000_0100, "R6");
      while ((m_cnt[1] & 64'h3FF) != 64'h3FF) cyc(1, 0, 0, A_LO, 0, "R2");
      cyc(1, 1, 0, A_LO, 0, "R4");
      cyc(0, 1, 0, A_HI, 0, "R4");
      cyc(0, 1, 0, A_LO, 0, "R4");
      // R5: ticks alone leave the latch
      for (int k = 0; k < 1100; k++) cyc(1, 0, 0, A_LO, 0, "R5");
      cyc(0, 1, 0, A_HI, 0, "R5");
      cyc(0, 1, 0, A_LO, 0, "R5");
      cyc(0, 1, 0, A_HI, 0, "R5");
      // R2: wrap of the narrow counter
      while (m_cnt[1] != 64'hFFF) cyc(1, 0, 0, A_LO, 0, "R2");
      cyc(1, 1, 0, A_LO, 0, "R2");
      cyc(0, 1, 0, A_LO, 0, "R2");
      cyc(0, 1, 0, A_HI, 0, "R2");

      // Random mix
      for (int k = 0; k < 4000; k++) begin
         bit          tk = 1'($urandom_range(0, 1));
         int unsigned op = $urandom_range(0, 9);
         logic [31:0] wd = $urandom;
         case (op)
            0, 1, 2: cyc(tk, 1, 0, A_LO, 0, "R4");
            3, 4:    cyc(tk, 1, 0, A_HI, 0, "R5");
            5: begin
               wd[8] = ($urandom_range(0, 7) != 0);
               cyc(tk, 0, 1, A_HI, wd, "R6");
            end
            6:       cyc(tk, 0, 1, A_LO, wd, "R7");
            7:       cyc(tk, 1, 0, A_OTH, 0, "R7");
            default: cyc(tk, 0, 0, A_LO, 0, "R2");
         endcase
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule